// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps events on an external capture pin. It watches the pin for the edge that an edge-select input picks. When that edge arrives, it copies the present value of an external free-running counter into a capture register and sets a sticky capture flag. An interrupt line is high while the flag is set and the interrupt enable is high. Software clears the flag with a one-cycle clear strobe.

The pin is asynchronous to the block clock. It passes through a two-stage synchronizer. Edges are found by comparing successive synchronized samples, so changing the edge polarity at run time cannot create a false event.

A mode input tells the block that the capture register currently serves as the counter's TOP value. While that input is high, the pin is treated as disconnected: neither the register nor the flag changes. Noise filtering, the counter itself and waveform generation are outside this block.

Top module: `icap_unit`

## Requirements
- R1: With `edgeSel` = 1 only a low-to-high transition of `capPin` causes a capture. With `edgeSel` = 0 only a high-to-low transition causes one.
- R2: A capture becomes visible on `capReg` and `capFlag` right after the third rising clock edge that follows the pin transition. After the second edge, nothing has changed yet.
- R3: On a capture, `capReg` takes the `cntVal` present at the capturing clock edge. A later capture overwrites `capReg` even while `capFlag` is still set, and `capReg` never changes without `capFlag` being set.
- R4: Changing `edgeSel` while `capPin` is steady causes no capture.
- R5: While `topMode` is 1 in the capturing cycle, neither `capReg` nor `capFlag` changes. An edge that arrives during `topMode` is consumed and does not cause a capture after `topMode` drops.
- R6: `capFlag` stays set until a cycle with `flagClr` = 1. If a clear and a capture fall in the same cycle, the flag stays set.
- R7: `capIrq` is 1 exactly when `capFlag` is 1 and `intEn` is 1.
- R8: While `rstN` is low, `capReg` is 0 and `capFlag` and `capIrq` are 0.
- R9: Until the synchronizer and edge history hold real pin samples after reset (three clock edges), no edge is recognised. A pin held high through reset therefore causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| capPin | input | 1 | Asynchronous capture pin |
| edgeSel | input | 1 | Trigger polarity: 1 rising, 0 falling |
| topMode | input | 1 | 1 while the capture register acts as counter TOP; capture suppressed |
| cntVal | input | 16 | Present value of the free-running counter |
| flagClr | input | 1 | One-cycle strobe clearing the capture flag |
| intEn | input | 1 | Interrupt enable |
| capReg | output | 16 | Captured counter value |
| capFlag | output | 1 | Sticky capture flag |
| capIrq | output | 1 | Interrupt request |

## Verification
If the edge history is wrong, it shows as a capture after a polarity change, after leaving TOP mode or after reset. Such a faulty capture appears on `capFlag` within three cycles of the stimulus. A synchronizer of the wrong depth moves the flag and the captured counter value by a whole cycle. This is visible because the counter input changes every cycle around each capture. A broken set-versus-clear priority shows on `capFlag` one cycle after the colliding cycle.

// File: rtl/icap_pkg.sv
package icap_pkg;

  // strobes from the control path to the datapath
  typedef struct packed {
    logic load;
  } icapStb_t;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/icap_ctrl.sv
module icap_ctrl
  import icap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     capPin,
  input  logic     edgeSel,
  input  logic     topMode,
  input  logic     flagClr,
  output icapStb_t ctrlStb,
  output logic     capFlag
);

  localparam int PRIME   = SYNC_STAGES + 1;
  localparam int PRIME_W = $clog2(PRIME + 1);

  logic               pinSync;
  logic               pinPrev;
  logic [PRIME_W-1:0] primeCnt;
  logic               primed;
  logic               riseSeen;
  logic               fallSeen;
  logic               trigger;

  icap_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (capPin),
    .syncOut (pinSync)
  );

  // one-sample edge history, always tracking regardless of mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinSync;
  end

  // history is trusted only once it holds real pin samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             primeCnt <= '0;
    else if (primeCnt != PRIME_W'(PRIME))  primeCnt <= primeCnt + 1'b1;
  end

  assign primed   = (primeCnt == PRIME_W'(PRIME));
  assign riseSeen = pinSync & ~pinPrev;
  assign fallSeen = ~pinSync & pinPrev;
  assign trigger  = primed & (edgeSel ? riseSeen : fallSeen);

  always_comb begin
    ctrlStb      = '0;
    ctrlStb.load = trigger & ~topMode;
  end

  // set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             capFlag <= 1'b0;
    else if (ctrlStb.load) capFlag <= 1'b1;
    else if (flagClr)      capFlag <= 1'b0;
  end

endmodule

// File: rtl/icap_dp.sv
module icap_dp
  import icap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  icapStb_t         ctrlStb,
  input  logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] capReg
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             capReg <= '0;
    else if (ctrlStb.load) capReg <= cntVal;
  end

endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capPin,
  input  logic             edgeSel,
  input  logic             topMode,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             flagClr,
  input  logic             intEn,
  output logic [CNT_W-1:0] capReg,
  output logic             capFlag,
  output logic             capIrq
);

  icapStb_t ctrlStb;

  icap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .capPin  (capPin),
    .edgeSel (edgeSel),
    .topMode (topMode),
    .flagClr (flagClr),
    .ctrlStb (ctrlStb),
    .capFlag (capFlag)
  );

  icap_dp #(.CNT_W(CNT_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlStb (ctrlStb),
    .cntVal  (cntVal),
    .capReg  (capReg)
  );

  assign capIrq = capFlag & intEn;

endmodule

// File: rtl/icap_chk.sv
module icap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             topMode,
  input logic             flagClr,
  input logic             intEn,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] capReg,
  input logic             capFlag,
  input logic             capIrq,
  input logic             loadStb
);

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> capReg == $past(cntVal)); // R3

  AST_REG_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capReg) |-> capFlag); // R3

  AST_TOP_HOLDS_REG: assert property (@(posedge clk) disable iff (!rstN)
    topMode |=> $stable(capReg)); // R5

  AST_TOP_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (topMode && !capFlag) |=> !capFlag); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClr) |=> capFlag); // R6

  AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !loadStb) |=> !capFlag); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |-> !capIrq); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    capIrq |-> capFlag); // R7

endmodule

bind icap_unit icap_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .topMode (topMode),
  .flagClr (flagClr),
  .intEn   (intEn),
  .cntVal  (cntVal),
  .capReg  (capReg),
  .capFlag (capFlag),
  .capIrq  (capIrq),
  .loadStb (ctrlStb.load)
);

// File: tb/icap_unit_tb_top.sv
`timescale 1ns/1ps
module icap_unit_tb_top;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN;
  logic             capPin;
  logic             edgeSel;
  logic             topMode;
  logic [CNT_W-1:0] cntVal;
  logic             flagClr;
  logic             intEn;
  logic [CNT_W-1:0] capReg;
  logic             capFlag;
  logic             capIrq;

  always #4 clk = ~clk; // 125 MHz

  icap_unit #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .capPin  (capPin),
    .edgeSel (edgeSel),
    .topMode (topMode),
    .cntVal  (cntVal),
    .flagClr (flagClr),
    .intEn   (intEn),
    .capReg  (capReg),
    .capFlag (capFlag),
    .capIrq  (capIrq)
  );

  typedef struct {
    logic [CNT_W-1:0] reg_;
    logic             flag;
    logic             irq;
    string            req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model of the expected state
  logic [CNT_W-1:0] mReg  = '0;
  logic             mFlag = 1'b0;

  // monitor: compares one expected item at each falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (capReg !== it.reg_ || capFlag !== it.flag || capIrq !== it.irq) begin
        errors++;
        $display("FAIL %s: reg=%h flag=%b irq=%b expected reg=%h flag=%b irq=%b",
                 it.req, capReg, capFlag, capIrq, it.reg_, it.flag, it.irq);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expectNow(string req);
    expItem_t it;
    it.reg_ = mReg;
    it.flag = mFlag;
    it.irq  = mFlag & intEn;
    it.req  = req;
    expQ.push_back(it);
  endtask

  // drive a pin transition; cntVal walks a, b, c; c is sampled at the capture edge
  task automatic pinEdge(logic newPin, logic [CNT_W-1:0] a, logic [CNT_W-1:0] b,
                         logic [CNT_W-1:0] c, bit clrAtCap, bit expectCap, string req);
    capPin = newPin;
    cntVal = a;
    tick();
    cntVal = b;
    tick();
    expectNow("R2 no change after two edges");
    cntVal = c;
    if (clrAtCap) flagClr = 1'b1;
    tick();
    flagClr = 1'b0;
    if (expectCap) begin
      mReg  = c;
      mFlag = 1'b1;
    end else if (clrAtCap) begin
      mFlag = 1'b0;
    end
    expectNow(req);
    cntVal = c + 1'b1;
    tick();
  endtask

  task automatic clearFlag();
    flagClr = 1'b1;
    tick();
    flagClr = 1'b0;
    mFlag   = 1'b0;
    expectNow("R6 clear strobe");
    tick();
  endtask

  initial begin
    rstN    = 1'b0;
    capPin  = 1'b1; // high through reset: R9
    edgeSel = 1'b1;
    topMode = 1'b0;
    cntVal  = '0;
    flagClr = 1'b0;
    intEn   = 1'b0;
    repeat (3) tick();
    expectNow("R8 reset state");
    tick();
    rstN = 1'b1;
    repeat (6) tick();
    expectNow("R9 pin high through reset not an edge");
    tick();

    // R1 falling edge ignored when rising selected
    pinEdge(1'b0, 16'h0010, 16'h0011, 16'h0012, 1'b0, 1'b0, "R1 fall ignored with edgeSel=1");

    // R1/R3 rising capture
    pinEdge(1'b1, 16'h1234, 16'h1235, 16'h1236, 1'b0, 1'b1, "R1 R3 rising capture value");

    // R7 interrupt enable
    intEn = 1'b1;
    tick();
    expectNow("R7 irq with flag and enable");
    tick();
    intEn = 1'b0;
    tick();
    expectNow("R7 irq masked");
    tick();
    intEn = 1'b1;

    // R6 clear
    clearFlag();

    // R4 polarity change with steady pin (pin high)
    edgeSel = 1'b0;
    repeat (4) tick();
    expectNow("R4 edgeSel change no capture");
    tick();
    edgeSel = 1'b1;
    repeat (4) tick();
    expectNow("R4 edgeSel change back no capture");
    tick();

    // R1 falling capture with edgeSel=0
    edgeSel = 1'b0;
    pinEdge(1'b0, 16'hBEE0, 16'hBEE1, 16'hBEE2, 1'b0, 1'b1, "R1 falling capture edgeSel=0");

    // R3 overwrite while flag set
    pinEdge(1'b1, 16'h0AAA, 16'h0AAB, 16'h0AAC, 1'b0, 1'b0, "R1 rise ignored with edgeSel=0");
    pinEdge(1'b0, 16'hFFFD, 16'hFFFE, 16'hFFFF, 1'b0, 1'b1, "R3 overwrite while flag set");
    clearFlag();

    // R5 top mode suppresses capture
    topMode = 1'b1;
    pinEdge(1'b1, 16'h5550, 16'h5551, 16'h5552, 1'b0, 1'b0, "R5 rise in top mode");
    pinEdge(1'b0, 16'h5560, 16'h5561, 16'h5562, 1'b0, 1'b0, "R5 fall in top mode");
    topMode = 1'b0;
    repeat (4) tick();
    expectNow("R5 no late capture after top mode");
    tick();

    // R6 clear and capture collide: capture wins
    pinEdge(1'b1, 16'h7000, 16'h7001, 16'h7002, 1'b0, 1'b0, "R1 rise ignored before collision");
    pinEdge(1'b0, 16'h7770, 16'h7771, 16'h7772, 1'b1, 1'b1, "R6 capture beats clear");
    tick();
    expectNow("R6 flag still set after collision");
    tick();
    clearFlag();

    // R8 reset again mid-run
    rstN = 1'b0;
    mReg = '0;
    mFlag = 1'b0;
    tick();
    expectNow("R8 reset clears register");
    tick();
    rstN = 1'b1;
    repeat (3) tick();
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule